// File: doc/BRIEF.md
# Power-On Body-Bias Calibrator

This block tunes a set of independent module domains once after power-on. Each domain has its own signed body-bias code. Negative codes apply reverse bias and positive codes apply forward bias, one code step per bias increment. The calibrator takes the domains one at a time. For each one it walks the code upward from the strongest reverse setting. After every code change it waits a programmable settling time, then asks the domain to run its test at the target clock rate and reads back a pass/fail verdict.

The first code that passes is kept as that domain's operating setting, and the calibrator moves on to the next domain. A domain that fails at every code is left at the strongest forward code and flagged. When the last domain is finished, a done flag rises. All codes then stay frozen until the next start pulse.

The test stimulus, the response checking and the analog bias generation all sit outside this block. Each domain talks to it through a request/acknowledge pair that carries a pass bit.

Top module: `bias_calibrator`

## Requirements
- R1: After reset every bias code is 0, `done` is 0, every `dom_fail` bit is 0 and every `test_req` bit is 0.
- R2: A `start` pulse while idle calibrates domains strictly in ascending index order, one domain at a time. At most one `test_req` bit is high in any cycle.
- R3: Within a domain, the first code tested is -MAX_STEP. After each failing verdict the code rises by exactly one and the domain is tested again.
- R4: `test_req` of the domain under test rises exactly `settle_cyc`+1 clock cycles after its bias code was applied.
- R5: `test_req` stays high until the domain raises `test_ack`. `test_pass` is read only in the cycle `test_ack` is high while requested. Acknowledges and pass bits on domains that are not being tested have no effect.
- R6: On the first passing verdict the current code is kept as that domain's final code, and calibration moves to the next domain.
- R7: If the verdict at code +MAX_STEP also fails, the domain's `dom_fail` bit is set and its code stays at +MAX_STEP.
- R8: `done` is 0 while calibration runs. It rises once the last domain is settled and stays high, with all bias codes unchanged, until the next start.
- R9: A `start` pulse while a calibration is running is ignored: no domain is restarted and no extra test is requested.
- R10: Codes are CODE_W-bit two's complement. Domain d occupies `bias_code[d*CODE_W +: CODE_W]`, and every code stays within -MAX_STEP..+MAX_STEP.
- R11: A new start clears all `dom_fail` bits and recalibrates every domain from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches calibration |
| settle_cyc | input | SETTLE_W | Extra settling cycles after each code change |
| test_ack | input | NUM_DOM | Per domain: test finished, verdict valid |
| test_pass | input | NUM_DOM | Per domain: verdict, 1 = pass |
| test_req | output | NUM_DOM | Per domain: run the test at the current code |
| bias_code | output | NUM_DOM*CODE_W | Packed signed bias codes, one field per domain |
| dom_fail | output | NUM_DOM | Per domain: no code passed |
| done | output | 1 | All domains calibrated |

## Verification
The bench builds the block with four domains and a sweep of ±4 steps, so CODE_W is 4. With this sweep the full code range, the never-passing case and the exact +MAX_STEP pass all occur within a few dozen tests per run. This keeps many complete calibrations, each with a different random settle time and ack latency, well inside the cycle budget. Four domains are still enough to cover the hand-off from one domain to the next, including a domain that starts at a code it already held.

// File: rtl/bias_calibrator.sv
module bias_calibrator #(
  parameter int NUM_DOM  = 21,
  parameter int MAX_STEP = 16,
  parameter int SETTLE_W = 8,
  localparam int CODE_W  = $clog2(MAX_STEP + 1) + 1,
  localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [SETTLE_W-1:0]        settle_cyc,
  input  logic [NUM_DOM-1:0]         test_ack,
  input  logic [NUM_DOM-1:0]         test_pass,
  output logic [NUM_DOM-1:0]         test_req,
  output logic [NUM_DOM*CODE_W-1:0]  bias_code,
  output logic [NUM_DOM-1:0]         dom_fail,
  output logic                       done
);

  localparam logic signed [CODE_W-1:0] CODE_HI = CODE_W'(MAX_STEP);
  localparam logic signed [CODE_W-1:0] CODE_LO = -CODE_HI;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_TEST} st_t;

  st_t                       state;
  logic [DOM_W-1:0]          dom_q;
  logic [SETTLE_W-1:0]       cnt_q;
  logic signed [CODE_W-1:0]  bias_q [NUM_DOM];

  logic signed [CODE_W-1:0]  cur_code;
  logic                      ack_cur, pass_cur, last_dom;

  assign cur_code = bias_q[dom_q];
  assign ack_cur  = test_ack[dom_q];
  assign pass_cur = test_pass[dom_q];
  assign last_dom = (dom_q == DOM_W'(NUM_DOM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dom_q    <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      dom_fail <= '0;
      for (int i = 0; i < NUM_DOM; i++) bias_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          dom_q     <= '0;
          bias_q[0] <= CODE_LO;
          cnt_q     <= '0;
          done      <= 1'b0;
          dom_fail  <= '0;
          state     <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt_q >= settle_cyc) state <= S_TEST;
          else                     cnt_q <= cnt_q + 1'b1;
        end
        S_TEST: if (ack_cur) begin
          cnt_q <= '0;
          if (!pass_cur && cur_code != CODE_HI) begin
            bias_q[dom_q] <= cur_code + CODE_W'(1);
            state         <= S_SETTLE;
          end else begin
            if (!pass_cur) dom_fail[dom_q] <= 1'b1;
            if (last_dom) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              dom_q                 <= dom_q + 1'b1;
              bias_q[dom_q + 1'b1]  <= CODE_LO;
              state                 <= S_SETTLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    test_req = '0;
    if (state == S_TEST) test_req[dom_q] = 1'b1;
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign bias_code[g*CODE_W +: CODE_W] = bias_q[g];

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_q[g] >= CODE_LO) && (bias_q[g] <= CODE_HI)); // R10
    AST_FAIL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      dom_fail[g] |-> bias_q[g] == CODE_HI); // R7
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req[g] && test_ack[g] && !test_pass[g] && bias_q[g] != CODE_HI)
      |=> bias_q[g] == $past(bias_q[g]) + CODE_W'(1)); // R3
    AST_KEEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req[g] && test_ack[g] && test_pass[g]) |=> bias_q[g] == $past(bias_q[g])); // R6
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(test_req)); // R2
  AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req != '0) |-> !done); // R8
  AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(bias_code)); // R8

endmodule

// File: tb/sim_bias_calibrator.sv
module sim_bias_calibrator;
  localparam int ND = 4;
  localparam int MS = 4;
  localparam int SW = 4;
  localparam int CW = $clog2(MS + 1) + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [SW-1:0] settle = '0;
  logic [ND-1:0] ack = '0, pass = '0, test_req, dom_fail;
  logic [ND*CW-1:0] bias_code;
  logic done;

  int total = 0, bad = 0, cyc = 0;
  int thr [ND];
  int lat [ND];
  bit arm = 0, st_q = 0, mon_en = 0;
  int cnt = 0, lastdom = -1, lastcode = 0, rises = 0;
  logic [ND-1:0] prev_req = '0;
  logic [ND*CW-1:0] prev_bias = '0;

  bias_calibrator #(.NUM_DOM(ND), .MAX_STEP(MS), .SETTLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cyc(settle),
    .test_ack(ack), .test_pass(pass), .test_req(test_req),
    .bias_code(bias_code), .dom_fail(dom_fail), .done(done));

  always #10 clk = ~clk;

  function automatic int code_of(int d);
    return int'($signed(bias_code[d*CW +: CW]));
  endfunction
  function automatic int exp_code(int t);
    return (t > MS) ? MS : t;
  endfunction
  function automatic int exp_tests(int t);
    return (t > MS) ? 2*MS + 1 : t + MS + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    st_q <= start && arm;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // domain model: verdict = code >= threshold; noise on idle domains and before ack (R5)
  always @(negedge clk) begin
    for (int d = 0; d < ND; d++) begin
      if (test_req[d]) begin
        if (lat[d] == 0) begin
          ack[d] = 1'b1;
          pass[d] = (code_of(d) >= thr[d]);
          lat[d] = int'($urandom % 4);
        end else begin
          ack[d] = 1'b0;
          pass[d] = 1'($urandom);
          lat[d]--;
        end
      end else begin
        ack[d] = 1'($urandom);
        pass[d] = 1'($urandom);
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (st_q) begin lastdom = -1; cnt = 0; end
      else if (bias_code != prev_bias || (prev_req != '0 && test_req == '0)) cnt = 0;
      else cnt++;
      if (prev_req == '0 && test_req != '0) begin
        int d;
        d = 0;
        for (int i = 0; i < ND; i++) if (test_req[i]) d = i;
        rises++;
        chk(cnt == int'(settle) + 1, "R4 settle", cnt, int'(settle) + 1);
        if (d == lastdom) begin
          chk(code_of(d) == lastcode + 1, "R3 step", code_of(d), lastcode + 1);
        end else begin
          chk(d == lastdom + 1, "R2 order", d, lastdom + 1);
          chk(code_of(d) == -MS, "R3 first code", code_of(d), -MS);
        end
        lastdom = d;
        lastcode = code_of(d);
      end
    end
    prev_req = test_req;
    prev_bias = bias_code;
  end

  task automatic pulse_start(bit real_one);
    @(negedge clk);
    arm = real_one;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_cal(int mode, bit disturb);
    int expn, w;
    expn = 0;
    for (int d = 0; d < ND; d++) begin
      case (mode)
        0: thr[d] = -MS;
        1: thr[d] = MS + 1;
        2: thr[d] = MS;
        default: thr[d] = int'($urandom % (2*MS + 2)) - MS;
      endcase
      lat[d] = int'($urandom % 4);
      expn += exp_tests(thr[d]);
    end
    settle = SW'($urandom % 6);
    rises = 0;
    pulse_start(1'b1);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done low while busy", int'(done), 0);
    if (disturb) begin
      repeat (5) @(negedge clk);
      pulse_start(1'b0); // R9
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R8 done rises", int'(done), 1);
    chk(rises == expn, disturb ? "R9 ignored restart" : "R6 test count", rises, expn);
    for (int d = 0; d < ND; d++) begin
      chk(code_of(d) == exp_code(thr[d]), (thr[d] > MS) ? "R7 code at top" : "R6 kept code",
          code_of(d), exp_code(thr[d]));
      chk(dom_fail[d] == (thr[d] > MS), "R7 fail bit", int'(dom_fail[d]), int'(thr[d] > MS));
    end
    begin
      logic [ND*CW-1:0] snap;
      snap = bias_code;
      repeat (20) @(negedge clk);
      chk(bias_code == snap, "R8 codes hold", int'(bias_code), int'(snap));
      chk(done == 1'b1 && test_req == '0, "R8 done holds", int'(done), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < ND; d++) begin thr[d] = 0; lat[d] = 0; end
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(bias_code == '0, "R1 codes", int'(bias_code), 0);
    chk(dom_fail == '0, "R1 fail", int'(dom_fail), 0);
    chk(test_req == '0, "R1 req", int'(test_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    run_cal(0, 1'b0);      // all pass at strongest reverse
    run_cal(1, 1'b0);      // nothing passes (R7)
    run_cal(2, 1'b0);      // pass only at the top code
    run_cal(0, 1'b0);      // R11: fail bits clear, domains restart at -MS
    chk(dom_fail == '0, "R11 fail cleared", int'(dom_fail), 0);
    run_cal(3, 1'b1);      // R9 restart during run
    for (int k = 0; k < 12; k++) run_cal(3, k[0]);
    for (int d = 0; d < ND; d++)
      chk(bias_code[d*CW +: CW] == CW'(exp_code(thr[d])), "R10 field position",
          int'(bias_code[d*CW +: CW]), exp_code(thr[d]));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule